// File: doc/BRIEF.md
# Accumulator Instruction-Set Processor Core

This block is a small multi-cycle processor with one 8-bit accumulator. Each 8-bit instruction is read from an internal 32-entry program memory. Its top three bits are an operation code and its low five bits are an operand. Depending on the operation, the operand is a two's-complement constant that is sign-extended to the accumulator width, or a direct address into a 32-entry data memory. Nine operations are available. Load, add and subtract each come in an immediate form and a memory form. The other three are store, an unconditional jump and a jump taken on a zero accumulator.

The data memory keeps writing and reading on separate buses. Write data always comes from the accumulator. Read data feeds only the arithmetic operand path. The controller has two named states. ST_FETCH latches the instruction at the program counter and increments the counter, then moves to ST_EXEC. ST_EXEC updates the accumulator, the data memory or the program counter, then returns to ST_FETCH. Synchronous reset forces ST_FETCH. While `run` is low the controller holds whatever state it is in.

While the core is held, a surrounding agent preloads both memories through a side port. The data memory can be read back at any time through that port.

Top module: `acc_cpu`

## Requirements
- R1: A synchronous reset sets the program counter and the accumulator to 0, puts the controller in ST_FETCH and holds `exec_valid` low. Memory contents are left as they were.
- R2: With `run` high, every instruction takes two cycles. A fetch cycle (`exec_valid` low) increments the program counter by 1 modulo 32. It is followed by one execute cycle (`exec_valid` high).
- R3: Opcode 000 loads the accumulator with the operand bits [4:0], sign-extended from bit 4 to 8 bits.
- R4: Opcode 001 adds the sign-extended constant to the accumulator. Opcode 010 subtracts it. Both results wrap modulo 256.
- R5: Opcode 011 loads the accumulator with data memory at address bits [4:0]. Opcode 100 adds that word and opcode 101 subtracts it, both modulo 256.
- R6: Opcode 110 writes the accumulator into data memory at address bits [4:0] and leaves the accumulator unchanged.
- R7: Opcode 111 with bit 4 clear sets the program counter to bits [3:0], zero-extended.
- R8: Opcode 111 with bit 4 set sets the program counter to bits [3:0] only when the accumulator is 0. Otherwise the incremented program counter is kept.
- R9: While `run` is low, the program counter, the accumulator and the controller state hold their values. The side-port write strobes `pm_we` and `dm_we` take effect only while `run` is low and are ignored while it is high.
- R10: `dm_rdata` shows the data memory word at `dm_addr` combinationally, and a store is visible there one cycle after its execute edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| run | input | 1 | Core advances when high; side-port writes allowed when low |
| pm_we | input | 1 | Program memory preload strobe |
| pm_addr | input | 5 | Program memory preload address |
| pm_wdata | input | 8 | Program memory preload word |
| dm_we | input | 1 | Data memory side-port write strobe |
| dm_addr | input | 5 | Data memory side-port address |
| dm_wdata | input | 8 | Data memory side-port write word |
| dm_rdata | output | 8 | Data memory word at `dm_addr` |
| acc_o | output | 8 | Accumulator |
| pc_o | output | 5 | Program counter |
| exec_valid | output | 1 | High in the execute cycle |

## Verification
A reference model steps beside the core over a program with several risky cases. One negative constant pushes a sign-extension error into the accumulator, so a zero-extending core would diverge at once. An add overflows 0x7F to 0x80 and a memory add wraps to zero; a core that saturated, or that kept a ninth bit, would fail there. The zero-conditional jump is exercised both taken and not taken, so inverting its test or ignoring the accumulator moves the program counter wrongly. A side-port write attempted while running, and a hold with `run` low, expose a core that lets the preload port override stores or keeps advancing while held.

// File: rtl/acc_pkg.sv
package acc_pkg;

    typedef enum logic [2:0] {
        OP_LDI  = 3'd0,
        OP_ADDI = 3'd1,
        OP_SUBI = 3'd2,
        OP_LDM  = 3'd3,
        OP_ADDM = 3'd4,
        OP_SUBM = 3'd5,
        OP_STM  = 3'd6,
        OP_JUMP = 3'd7
    } op_e;

    typedef enum logic {
        ST_FETCH = 1'b0,
        ST_EXEC  = 1'b1
    } state_e;

    typedef enum logic [1:0] {
        ALU_PASS = 2'd0,
        ALU_ADD  = 2'd1,
        ALU_SUB  = 2'd2
    } alu_e;

    typedef struct packed {
        logic acc_we;
        logic mem_src;
        alu_e alu_op;
        logic mem_we;
        logic jump;
        logic jump_cond;
    } ctrl_t;

endpackage

// File: rtl/acc_decode.sv
module acc_decode
    import acc_pkg::*;
(
    input  op_e   opcode,
    output ctrl_t ctrl
);

    always_comb begin
        ctrl = '{acc_we: 1'b0, mem_src: 1'b0, alu_op: ALU_PASS,
                 mem_we: 1'b0, jump: 1'b0, jump_cond: 1'b0};
        unique case (opcode)
            OP_LDI:  begin ctrl.acc_we = 1'b1; ctrl.alu_op = ALU_PASS; end
            OP_ADDI: begin ctrl.acc_we = 1'b1; ctrl.alu_op = ALU_ADD;  end
            OP_SUBI: begin ctrl.acc_we = 1'b1; ctrl.alu_op = ALU_SUB;  end
            OP_LDM:  begin ctrl.acc_we = 1'b1; ctrl.mem_src = 1'b1; ctrl.alu_op = ALU_PASS; end
            OP_ADDM: begin ctrl.acc_we = 1'b1; ctrl.mem_src = 1'b1; ctrl.alu_op = ALU_ADD;  end
            OP_SUBM: begin ctrl.acc_we = 1'b1; ctrl.mem_src = 1'b1; ctrl.alu_op = ALU_SUB;  end
            OP_STM:  begin ctrl.mem_we = 1'b1; end
            OP_JUMP: begin ctrl.jump = 1'b1; ctrl.jump_cond = 1'b1; end
            default: begin ctrl.acc_we = 1'b0; end
        endcase
    end

endmodule

// File: rtl/acc_alu.sv
module acc_alu
    import acc_pkg::*;
#(
    parameter int DW   = 8,
    parameter int ARGW = 5
) (
    input  alu_e            alu_op,
    input  logic            mem_src,
    input  logic [DW-1:0]   acc,
    input  logic [DW-1:0]   mem_word,
    input  logic [ARGW-1:0] imm,
    output logic [DW-1:0]   result
);

    localparam int EXTW = DW - ARGW;

    logic [DW-1:0] imm_ext;
    logic [DW-1:0] operand;

    assign imm_ext = {{EXTW{imm[ARGW-1]}}, imm};
    assign operand = mem_src ? mem_word : imm_ext;

    always_comb begin
        unique case (alu_op)
            ALU_ADD:  result = acc + operand;
            ALU_SUB:  result = acc - operand;
            default:  result = operand;
        endcase
    end

endmodule

// File: rtl/acc_ram.sv
module acc_ram #(
    parameter int DW  = 8,
    parameter int AW  = 5,
    parameter int NRD = 1
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [DW-1:0] wdata,
    input  logic [AW-1:0] raddr [NRD],
    output logic [DW-1:0] rdata [NRD]
);

    localparam int DEPTH = 1 << AW;

    logic [DW-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we) begin
            mem[waddr] <= wdata;
        end
    end

    for (genvar g = 0; g < NRD; g++) begin : g_rd
        assign rdata[g] = mem[raddr[g]];
    end

endmodule

// File: rtl/acc_cpu.sv
module acc_cpu
    import acc_pkg::*;
#(
    parameter int DW   = 8,
    parameter int PCW  = 5,
    parameter int ARGW = 5
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            run,
    input  logic            pm_we,
    input  logic [PCW-1:0]  pm_addr,
    input  logic [DW-1:0]   pm_wdata,
    input  logic            dm_we,
    input  logic [ARGW-1:0] dm_addr,
    input  logic [DW-1:0]   dm_wdata,
    output logic [DW-1:0]   dm_rdata,
    output logic [DW-1:0]   acc_o,
    output logic [PCW-1:0]  pc_o,
    output logic            exec_valid
);

    localparam int OPW  = 3;
    localparam int IW   = OPW + ARGW;
    localparam int TGTW = ARGW - 1;

    state_e          state_q, state_d;
    logic [PCW-1:0]  pc_q;
    logic [DW-1:0]   acc_q;
    logic [IW-1:0]   ir_q;

    op_e             opcode;
    logic [ARGW-1:0] arg;
    logic [PCW-1:0]  target;
    ctrl_t           ctrl;
    logic [DW-1:0]   alu_res;
    logic            take_jump;

    logic [PCW-1:0]  pm_raddr [1];
    logic [IW-1:0]   pm_rdata [1];
    logic [ARGW-1:0] dm_raddr [2];
    logic [DW-1:0]   dm_rd    [2];
    logic            dm_wen;
    logic [ARGW-1:0] dm_waddr;
    logic [DW-1:0]   dm_wword;

    assign opcode = op_e'(ir_q[IW-1 -: OPW]);
    assign arg    = ir_q[ARGW-1:0];
    assign target = PCW'(ir_q[TGTW-1:0]);

    acc_decode u_dec (
        .opcode (opcode),
        .ctrl   (ctrl)
    );

    acc_alu #(.DW(DW), .ARGW(ARGW)) u_alu (
        .alu_op   (ctrl.alu_op),
        .mem_src  (ctrl.mem_src),
        .acc      (acc_q),
        .mem_word (dm_rd[0]),
        .imm      (arg),
        .result   (alu_res)
    );

    // Program memory: preload only while held, read at the program counter
    assign pm_raddr[0] = pc_q;

    acc_ram #(.DW(IW), .AW(PCW), .NRD(1)) u_pmem (
        .clk   (clk),
        .we    (pm_we && !run),
        .waddr (pm_addr),
        .wdata (pm_wdata),
        .raddr (pm_raddr),
        .rdata (pm_rdata)
    );

    // Data memory: write bus from accumulator (or side port when held),
    // separate read buses for the operand path and the side port
    assign dm_wen      = run ? (state_q == ST_EXEC && ctrl.mem_we) : dm_we;
    assign dm_waddr    = run ? arg   : dm_addr;
    assign dm_wword    = run ? acc_q : dm_wdata;
    assign dm_raddr[0] = arg;
    assign dm_raddr[1] = dm_addr;

    acc_ram #(.DW(DW), .AW(ARGW), .NRD(2)) u_dmem (
        .clk   (clk),
        .we    (dm_wen),
        .waddr (dm_waddr),
        .wdata (dm_wword),
        .raddr (dm_raddr),
        .rdata (dm_rd)
    );

    assign take_jump = ctrl.jump && (!ir_q[ARGW-1] || acc_q == '0);

    always_comb begin
        unique case (state_q)
            ST_FETCH: state_d = ST_EXEC;
            ST_EXEC:  state_d = ST_FETCH;
            default:  state_d = ST_FETCH;
        endcase
    end

    // State register
    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_FETCH;
        end else if (run) begin
            state_q <= state_d;
        end
    end

    // Architectural registers
    always_ff @(posedge clk) begin
        if (rst) begin
            pc_q  <= '0;
            acc_q <= '0;
            ir_q  <= '0;
        end else if (run) begin
            unique case (state_q)
                ST_FETCH: begin
                    ir_q <= pm_rdata[0];
                    pc_q <= pc_q + 1'b1;
                end
                ST_EXEC: begin
                    if (ctrl.acc_we) acc_q <= alu_res;
                    if (take_jump)   pc_q  <= target;
                end
                default: pc_q <= pc_q;
            endcase
        end
    end

    // Outputs
    always_comb begin
        exec_valid = (state_q == ST_EXEC);
        acc_o      = acc_q;
        pc_o       = pc_q;
        dm_rdata   = dm_rd[1];
    end

endmodule

// File: rtl/acc_cpu_chk.sv
module acc_cpu_chk #(
    parameter int DW   = 8,
    parameter int PCW  = 5,
    parameter int ARGW = 5
) (
    input logic              clk,
    input logic              rst,
    input logic              run,
    input logic              exec_valid,
    input logic [PCW-1:0]    pc_o,
    input logic [DW-1:0]     acc_o,
    input logic [ARGW+2:0]   ir
);

    localparam int IW = ARGW + 3;

    logic [2:0]    op_f;
    logic [DW-1:0] sext_imm;

    assign op_f     = ir[IW-1 -: 3];
    assign sext_imm = {{(DW-ARGW){ir[ARGW-1]}}, ir[ARGW-1:0]};

    // R1
    reset_clear_chk: assert property (@(posedge clk)
        rst |=> (pc_o == '0 && acc_o == '0 && !exec_valid));

    // R2
    fetch_step_chk: assert property (@(posedge clk) disable iff (rst)
        (run && !exec_valid) |=> (exec_valid && pc_o == PCW'($past(pc_o) + 1'b1)));

    // R2
    exec_return_chk: assert property (@(posedge clk) disable iff (rst)
        (run && exec_valid) |=> !exec_valid);

    // R9
    hold_chk: assert property (@(posedge clk) disable iff (rst)
        !run |=> ($stable(pc_o) && $stable(acc_o) && $stable(exec_valid)));

    // R3
    imm_load_chk: assert property (@(posedge clk) disable iff (rst)
        (run && exec_valid && op_f == 3'd0) |=> (acc_o == $past(sext_imm)));

    // R6
    store_keeps_acc_chk: assert property (@(posedge clk) disable iff (rst)
        (run && exec_valid && op_f == 3'd6) |=> $stable(acc_o));

    // R7
    jump_target_chk: assert property (@(posedge clk) disable iff (rst)
        (run && exec_valid && op_f == 3'd7 && !ir[ARGW-1])
        |=> (pc_o == PCW'($past(ir[ARGW-2:0]))));

    // R8
    jz_skip_chk: assert property (@(posedge clk) disable iff (rst)
        (run && exec_valid && op_f == 3'd7 && ir[ARGW-1] && acc_o != '0)
        |=> $stable(pc_o));

endmodule

bind acc_cpu acc_cpu_chk #(.DW(DW), .PCW(PCW), .ARGW(ARGW)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .run        (run),
    .exec_valid (exec_valid),
    .pc_o       (pc_o),
    .acc_o      (acc_o),
    .ir         (ir_q)
);

// File: tb/sim_acc_cpu.sv
module sim_acc_cpu;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       run = 1'b0;
    logic       pm_we = 1'b0;
    logic [4:0] pm_addr = '0;
    logic [7:0] pm_wdata = '0;
    logic       dm_we = 1'b0;
    logic [4:0] dm_addr = '0;
    logic [7:0] dm_wdata = '0;
    logic [7:0] dm_rdata;
    logic [7:0] acc_o;
    logic [4:0] pc_o;
    logic       exec_valid;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #4 clk = ~clk;

    acc_cpu u0 (
        .clk(clk), .rst(rst), .run(run),
        .pm_we(pm_we), .pm_addr(pm_addr), .pm_wdata(pm_wdata),
        .dm_we(dm_we), .dm_addr(dm_addr), .dm_wdata(dm_wdata),
        .dm_rdata(dm_rdata), .acc_o(acc_o), .pc_o(pc_o),
        .exec_valid(exec_valid)
    );

    // Program vectors: instruction word at each program address
    localparam int NPROG = 18;
    localparam logic [7:0] PROG [NPROG] = '{
        8'h1D, // 0  LDI -3        -> FD          R3
        8'h25, // 1  ADDI 5        -> 02          R4
        8'h50, // 2  SUBI -16      -> 12          R4
        8'h80, // 3  ADDM [0]      -> 17          R5
        8'hCA, // 4  STM [10]                     R6
        8'hA1, // 5  SUBM [1]=-2   -> 19          R5
        8'h62, // 6  LDM [2]       -> 7F          R5
        8'h21, // 7  ADDI 1        -> 80 wrap     R4
        8'h83, // 8  ADDM [3]=80   -> 00 wrap     R5
        8'hFC, // 9  JZ 12 taken                  R8
        8'h01, // 10 skipped
        8'h01, // 11 skipped
        8'h07, // 12 LDI 7
        8'hF0, // 13 JZ 0 not taken               R8
        8'hCB, // 14 STM [11]                     R6
        8'h47, // 15 SUBI 7        -> 00
        8'hDF, // 16 STM [31]
        8'hEF  // 17 JMP 15                       R7
    };
    localparam logic [7:0] DINIT [4] = '{8'h05, 8'hFE, 8'h7F, 8'h80};

    logic [7:0] m_pm [32];
    logic [7:0] m_dm [32];
    logic [7:0] m_acc;
    logic [4:0] m_pc;

    task automatic check(input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    function automatic string req_of(input logic [7:0] ins);
        case (ins[7:5])
            3'd0:          return "R3";
            3'd1, 3'd2:    return "R4";
            3'd3, 3'd4, 3'd5: return "R5";
            3'd6:          return "R6";
            default:       return ins[4] ? "R8" : "R7";
        endcase
    endfunction

    // Reference model: one instruction
    task automatic model_step(output logic [7:0] ins);
        logic [7:0] imm;
        ins  = m_pm[m_pc];
        m_pc = m_pc + 5'd1;
        imm  = {{3{ins[4]}}, ins[4:0]};
        case (ins[7:5])
            3'd0: m_acc = imm;
            3'd1: m_acc = m_acc + imm;
            3'd2: m_acc = m_acc - imm;
            3'd3: m_acc = m_dm[ins[4:0]];
            3'd4: m_acc = m_acc + m_dm[ins[4:0]];
            3'd5: m_acc = m_acc - m_dm[ins[4:0]];
            3'd6: m_dm[ins[4:0]] = m_acc;
            default: if (!ins[4] || m_acc == 8'h00) m_pc = {1'b0, ins[3:0]};
        endcase
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual running expected finished");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        logic [7:0] ins;
        logic [4:0] h_pc;
        logic [7:0] h_acc;

        for (int i = 0; i < 32; i++) begin
            m_pm[i] = (i < NPROG) ? PROG[i] : 8'h00;
            m_dm[i] = (i < 4) ? DINIT[i] : 8'h00;
        end

        // Preload through the side port while held
        @(negedge clk);
        for (int i = 0; i < 32; i++) begin
            pm_we = 1'b1; pm_addr = 5'(i); pm_wdata = m_pm[i];
            dm_we = 1'b1; dm_addr = 5'(i); dm_wdata = m_dm[i];
            @(negedge clk);
        end
        pm_we = 1'b0; dm_we = 1'b0;

        // R1 reset state
        @(negedge clk);
        check("R1", "pc after reset", pc_o, 0);
        check("R1", "acc after reset", acc_o, 0);
        check("R1", "exec_valid in reset", exec_valid, 0);
        dm_addr = 5'd2;
        #1 check("R10", "preloaded word", dm_rdata, 8'h7F);

        rst = 1'b0; run = 1'b1;
        m_acc = 8'h00; m_pc = 5'd0;

        for (int n = 0; n < 24; n++) begin
            model_step(ins);
            @(negedge clk);
            check("R2", "exec_valid in execute", exec_valid, 1);
            @(negedge clk);
            check("R2", "exec_valid back to fetch", exec_valid, 0);
            check(req_of(ins), "pc", pc_o, m_pc);
            check(req_of(ins), "acc", acc_o, m_acc);
            if (ins[7:5] == 3'd6) begin
                dm_addr = ins[4:0];
                #1 check("R10", "stored word", dm_rdata, m_dm[ins[4:0]]);
                check("R6", "stored word", dm_rdata, m_acc);
            end
        end

        // R9 hold with run low, side-port write accepted
        run = 1'b0;
        h_pc = pc_o; h_acc = acc_o;
        dm_we = 1'b1; dm_addr = 5'd20; dm_wdata = 8'h3C;
        @(negedge clk);
        dm_we = 1'b0;
        repeat (3) @(negedge clk);
        check("R9", "pc held", pc_o, h_pc);
        check("R9", "acc held", acc_o, h_acc);
        check("R9", "fetch state held", exec_valid, 0);
        check("R10", "side write while held", dm_rdata, 8'h3C);

        // Resume and confirm the model still agrees
        run = 1'b1;
        for (int n = 0; n < 3; n++) begin
            model_step(ins);
            repeat (2) @(negedge clk);
            check(req_of(ins), "pc after resume", pc_o, m_pc);
            check(req_of(ins), "acc after resume", acc_o, m_acc);
        end

        // R9 side-port write ignored while running
        dm_we = 1'b1; dm_addr = 5'd21; dm_wdata = 8'h55;
        pm_we = 1'b1; pm_addr = 5'd25; pm_wdata = 8'hFF;
        @(negedge clk);
        dm_we = 1'b0; pm_we = 1'b0;
        #1 check("R9", "dm write ignored while running", dm_rdata, 8'h00);

        // R1 reset in mid-run
        rst = 1'b1;
        @(negedge clk);
        check("R1", "pc after mid-run reset", pc_o, 0);
        check("R1", "acc after mid-run reset", acc_o, 0);
        check("R1", "fetch after mid-run reset", exec_valid, 0);
        dm_addr = 5'd11;
        #1 check("R1", "memory kept over reset", dm_rdata, 8'h07);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule